// File: doc/BRIEF.md
# Halfword Instruction Prefetch Queue

This block sits between instruction memory and the decode stage of a core whose instructions are one, two or three 16-bit halfwords long. It asks the fetch port for consecutive 32-bit words, splits each returned word into two halfwords and keeps them in an eight-entry circular queue. The fetch port may take any number of cycles to answer, and several requests may be in flight at once.

The halfword at the head of the queue alone decides the length of the next instruction. When every halfword of that instruction is in the queue, the block presents it to decode with a valid flag. Otherwise the valid flag is low, and decode runs a no-operation for that cycle. Decode accepts an instruction with a take strobe, which removes exactly that many halfwords.

A redirect (a taken branch) empties the queue in one cycle and restarts fetching at the word that holds the target. If the target is the upper halfword of a word, the lower halfword of the first returned word is thrown away. Words still in flight from before the redirect are discarded when they arrive.

Top module: `hw_prefetch_queue`

## Requirements
- R1: When reset is released, `dec_valid` is 0, `fe_req_valid` is 1 and `fe_req_addr` equals `BOOT_ADDR` with its two low bits cleared.
- R2: Length encoding of the head halfword h: if h[15:12] is 4'b1111 the length is 3; otherwise, if h[15:14] is 2'b11, the length is 2; otherwise the length is 1. `dec_len` carries this as 1, 2 or 3.
- R3: `dec_valid` is 1 only when the queue holds at least `dec_len` halfwords. With fewer, `dec_valid` is 0 (a bubble), including when only part of an instruction has arrived.
- R4: A kept response word adds `fe_rsp_data[15:0]` (byte offset 0) to the queue before `fe_rsp_data[31:16]` (byte offset 2). `dec_hw0`, `dec_hw1` and `dec_hw2` are the first, second and third halfwords of the presented instruction, in address order.
- R5: A cycle with `dec_valid` and `dec_take` both high removes exactly `dec_len` halfwords. The next instruction starts at the halfword after them.
- R6: The queue holds 8 halfwords. A request is offered only when at least two slots are neither occupied nor reserved by a live in-flight request (two each), and no more than `MAX_INFLIGHT` requests are outstanding.
- R7: Accepted requests have word-aligned addresses that go up by 4 from one accepted request to the next, until a redirect.
- R8: A redirect empties the queue, so `dec_valid` is 0 in the following cycle. The next request address is the target with bits [1:0] cleared.
- R9: If the redirect target has bit 1 set, only `fe_rsp_data[31:16]` of the first kept word enters the queue.
- R10: Responses to requests accepted before a redirect, or in the redirect cycle, never enter the queue.
- R11: An instruction that is presented and not taken, with no redirect, stays presented unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_req_valid | output | 1 | Fetch request offered |
| fe_req_addr | output | ADDR_W | Word-aligned byte address of the request |
| fe_req_ack | input | 1 | Fetch port accepts the request in this cycle |
| fe_rsp_valid | input | 1 | Response word valid (in request order) |
| fe_rsp_data | input | 32 | Response word |
| redirect_valid | input | 1 | Taken branch: flush and refill |
| redirect_addr | input | ADDR_W-1 | Branch target as a halfword address (byte address bits ADDR_W-1:1) |
| dec_valid | output | 1 | Presented instruction is complete |
| dec_len | output | 2 | Length of the presented instruction in halfwords |
| dec_hw0 | output | 16 | First halfword of the instruction |
| dec_hw1 | output | 16 | Second halfword (meaningful when length is 2 or 3) |
| dec_hw2 | output | 16 | Third halfword (meaningful when length is 3) |
| dec_take | input | 1 | Decode accepts the presented instruction |

## Verification
The assertions assume three things about the inputs. The fetch port answers only requests it has accepted, and answers them in order. Decode raises `dec_take` only while `dec_valid` is high. Decode keeps `dec_take` low in a redirect cycle. The bench's fetch model keeps accepted addresses in a FIFO, answers from its head after a random number of wait states, and sends nothing when that FIFO is empty. Its consumer derives take from the sampled valid flag and never takes in a cycle in which it redirects.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

  typedef logic [15:0] hword_t;
  typedef logic [1:0]  ilen_t;

  // Instruction length from the head halfword (R2)
  function automatic ilen_t len_of_head(hword_t h);
    if (h[15:13] == 3'b111 && h[12]) return 2'd3;
    else if (h[15:14] == 2'b11)      return 2'd2;
    else                             return 2'd1;
  endfunction

  // Slots neither occupied nor promised to a live in-flight word
  function automatic int unsigned free_slots(int unsigned depth,
                                             int unsigned held,
                                             int unsigned live);
    if (held + 2 * live >= depth) return 0;
    else                          return depth - held - 2 * live;
  endfunction

endpackage

// File: rtl/ifq_len_decode.sv
module ifq_len_decode
  import ifq_pkg::*;
(
  input  hword_t head,
  output ilen_t  len
);
  assign len = len_of_head(head);

  always_comb begin
    AST_LEN_NONZERO: assert (len != 2'd0); // R2
  end
endmodule

// File: rtl/ifq_hw_ring.sv
module ifq_hw_ring
  import ifq_pkg::*;
#(
  parameter  int Q_DEPTH = 8,
  localparam int PW      = $clog2(Q_DEPTH),
  localparam int CW      = $clog2(Q_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    wr_cnt,
  input  hword_t        wr_d0,
  input  hword_t        wr_d1,
  input  logic [1:0]    rd_cnt,
  output logic [CW-1:0] count,
  output hword_t        peek0,
  output hword_t        peek1,
  output hword_t        peek2
);
  hword_t          slot [Q_DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;
  logic [PW-1:0]   wr_ptr_nx;
  logic [CW-1:0]   held;

  assign wr_ptr_nx = wr_ptr + PW'(1);
  assign count     = held;
  assign peek0     = slot[rd_ptr];
  assign peek1     = slot[rd_ptr + PW'(1)];
  assign peek2     = slot[rd_ptr + PW'(2)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      held   <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      held   <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(wr_cnt);
      rd_ptr <= rd_ptr + PW'(rd_cnt);
      held   <= held + CW'(wr_cnt) - CW'(rd_cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (wr_cnt != 2'd0) slot[wr_ptr]    <= wr_d0;
      if (wr_cnt == 2'd2) slot[wr_ptr_nx] <= wr_d1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !flush |-> (32'(held) + 32'(wr_cnt)) <= (32'(Q_DEPTH) + 32'(rd_cnt))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !flush |-> 32'(rd_cnt) <= 32'(held)); // R5
endmodule

// File: rtl/ifq_fetch_ctl.sv
module ifq_fetch_ctl
  import ifq_pkg::*;
#(
  parameter  int               ADDR_W       = 32,
  parameter  int               Q_DEPTH      = 8,
  parameter  int               MAX_INFLIGHT = 2,
  parameter  logic [ADDR_W-1:0] BOOT_ADDR   = '0,
  localparam int               CW           = $clog2(Q_DEPTH + 1),
  localparam int               OW           = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic [ADDR_W-1:1] redirect_hw,
  input  logic              req_ack,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  input  logic [CW-1:0]     q_count,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        wr_cnt,
  output hword_t            wr_d0,
  output hword_t            wr_d1,
  output logic              rsp_dropped
);
  logic [ADDR_W-1:0] fa;
  logic [OW-1:0]     out_cnt, stale_cnt, live_cnt;
  logic              skip_lo;
  logic              room_ok, accept, rsp_kept;
  logic              armed;

  assign live_cnt    = out_cnt - stale_cnt;
  assign room_ok     = free_slots(Q_DEPTH, 32'(q_count), 32'(live_cnt)) >= 32'd2;
  assign req_valid   = room_ok && (32'(out_cnt) < MAX_INFLIGHT);
  assign req_addr    = fa;
  assign accept      = req_valid && req_ack;

  assign rsp_dropped = rsp_valid && (redirect || stale_cnt != '0);
  assign rsp_kept    = rsp_valid && !rsp_dropped;
  assign wr_cnt      = !rsp_kept ? 2'd0 : (skip_lo ? 2'd1 : 2'd2);
  assign wr_d0       = skip_lo ? rsp_data[31:16] : rsp_data[15:0];
  assign wr_d1       = rsp_data[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa        <= {BOOT_ADDR[ADDR_W-1:2], 2'b00};
      out_cnt   <= '0;
      stale_cnt <= '0;
      skip_lo   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      armed   <= 1'b1;
      out_cnt <= out_cnt + OW'(accept) - OW'(rsp_valid);
      if (redirect) begin
        fa        <= {redirect_hw[ADDR_W-1:2], 2'b00};
        stale_cnt <= out_cnt + OW'(accept) - OW'(rsp_valid);
        skip_lo   <= redirect_hw[1];
      end else begin
        if (accept) fa <= fa + ADDR_W'(4);
        if (rsp_valid && stale_cnt != '0) stale_cnt <= stale_cnt - OW'(1);
        if (rsp_kept) skip_lo <= 1'b0;
      end
    end
  end

  AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) 32'(out_cnt) <= MAX_INFLIGHT); // R6
  AST_RSP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> out_cnt != '0); // R10
  AST_STALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) stale_cnt <= out_cnt); // R10
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (armed && req_valid && $past(accept && !redirect)) |-> req_addr == $past(req_addr) + ADDR_W'(4)); // R7
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (armed && $past(redirect)) |-> req_addr == {$past(redirect_hw[ADDR_W-1:2]), 2'b00}); // R8
endmodule

// File: rtl/hw_prefetch_queue.sv
module hw_prefetch_queue
  import ifq_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                Q_DEPTH      = 8,
  parameter int                MAX_INFLIGHT = 2,
  parameter logic [ADDR_W-1:0] BOOT_ADDR    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fe_req_valid,
  output logic [ADDR_W-1:0] fe_req_addr,
  input  logic              fe_req_ack,
  input  logic              fe_rsp_valid,
  input  logic [31:0]       fe_rsp_data,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:1] redirect_addr,
  output logic              dec_valid,
  output logic [1:0]        dec_len,
  output logic [15:0]       dec_hw0,
  output logic [15:0]       dec_hw1,
  output logic [15:0]       dec_hw2,
  input  logic              dec_take
);
  localparam int CW = $clog2(Q_DEPTH + 1);

  logic [CW-1:0] queue_count;
  logic [1:0]    wr_cnt, rd_cnt;
  hword_t        wr_d0, wr_d1;
  hword_t        head0, head1, head2;
  ilen_t         head_len;
  logic          instr_taken;
  logic          fetch_drop;

  ifq_fetch_ctl #(
    .ADDR_W(ADDR_W), .Q_DEPTH(Q_DEPTH),
    .MAX_INFLIGHT(MAX_INFLIGHT), .BOOT_ADDR(BOOT_ADDR)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .redirect(redirect_valid), .redirect_hw(redirect_addr),
    .req_ack(fe_req_ack), .rsp_valid(fe_rsp_valid), .rsp_data(fe_rsp_data),
    .q_count(queue_count),
    .req_valid(fe_req_valid), .req_addr(fe_req_addr),
    .wr_cnt(wr_cnt), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .rsp_dropped(fetch_drop)
  );

  ifq_hw_ring #(.Q_DEPTH(Q_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(redirect_valid),
    .wr_cnt(wr_cnt), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .rd_cnt(rd_cnt), .count(queue_count),
    .peek0(head0), .peek1(head1), .peek2(head2)
  );

  ifq_len_decode u_len (.head(head0), .len(head_len));

  assign dec_valid   = 32'(queue_count) >= 32'(head_len);
  assign dec_len     = head_len;
  assign dec_hw0     = head0;
  assign dec_hw1     = head1;
  assign dec_hw2     = head2;
  assign instr_taken = dec_valid && dec_take && !redirect_valid;
  assign rd_cnt      = instr_taken ? head_len : 2'd0;

  AST_BUBBLE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) redirect_valid |=> !dec_valid); // R8
  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) dec_take |-> dec_valid); // R5
  AST_HOLD_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && !dec_take && !redirect_valid) |=> (dec_valid && $stable(dec_hw0) && $stable(dec_len))); // R11
  AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n) fetch_drop |=> queue_count <= $past(queue_count)); // R10
endmodule

// File: tb/hw_prefetch_queue_test.sv
`timescale 1ns/1ps
module hw_prefetch_queue_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fe_req_valid;
  logic [AW-1:0] fe_req_addr;
  logic          fe_req_ack = 1'b0;
  logic          fe_rsp_valid = 1'b0;
  logic [31:0]   fe_rsp_data = '0;
  logic          redirect_valid = 1'b0;
  logic [AW-1:1] redirect_addr = '0;
  logic          dec_valid;
  logic [1:0]    dec_len;
  logic [15:0]   dec_hw0, dec_hw1, dec_hw2;
  logic          dec_take = 1'b0;

  always #2.5 clk = ~clk;

  hw_prefetch_queue uut (
    .clk(clk), .rst_n(rst_n),
    .fe_req_valid(fe_req_valid), .fe_req_addr(fe_req_addr), .fe_req_ack(fe_req_ack),
    .fe_rsp_valid(fe_rsp_valid), .fe_rsp_data(fe_rsp_data),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .dec_valid(dec_valid), .dec_len(dec_len),
    .dec_hw0(dec_hw0), .dec_hw1(dec_hw1), .dec_hw2(dec_hw2),
    .dec_take(dec_take)
  );

  typedef struct { logic [1:0] len; logic [15:0] h0, h1, h2; } item_t;
  typedef struct { logic [31:0] addr; int ready; } pend_t;

  item_t       exp_q[$];
  pend_t       pend[$];
  int          errors = 0, checks = 0, cyc = 0, acc_since = 0, budget = -1;
  bit          done = 0, ack_en = 0, dir_mode = 1, dir_take = 0;
  bit          redir_pend = 0, hold_chk = 0, after_redir = 0;
  logic [31:0] redir_tgt = '0, exp_pc = '0, exp_fa = '0;
  logic [15:0] held_h0 = '0;

  // Program image: 0x8000.. all 3-halfword, 0x4000.. all 2-halfword, below mixed
  function automatic logic [15:0] hw_at(logic [31:0] a);
    logic [31:0] m;
    if (a[15]) return {4'hF, a[12:1]};
    if (a[14]) return {3'b110, a[13:1]};
    m = a * 32'd40503;
    return m[23:8];
  endfunction

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {hw_at(a + 32'd2), hw_at(a)};
  endfunction

  function automatic logic [1:0] ref_len(logic [15:0] h);
    if (h >= 16'hF000) return 2'd3;
    if (h >= 16'hC000) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [31:0] pick_target();
    case ($urandom % 3)
      0:       return 32'h0100 + ($urandom % 1024) * 2;
      1:       return 32'h4000 + ($urandom % 512) * 2;
      default: return 32'h8000 + ($urandom % 512) * 2;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected instruction stream
  task automatic fill_expected();
    while (exp_q.size() < 8) begin
      item_t it;
      it.h0 = hw_at(exp_pc);
      it.len = ref_len(it.h0);
      it.h1 = hw_at(exp_pc + 32'd2);
      it.h2 = hw_at(exp_pc + 32'd4);
      exp_q.push_back(it);
      exp_pc = exp_pc + 32'(it.len) * 2;
    end
  endtask

  task automatic tick();
    bit redir_now, tk;
    item_t e;
    @(negedge clk);
    cyc++;
    redir_now = redir_pend;
    redir_pend = 0;
    tk = 0;
    if (!dir_mode) begin
      if (after_redir) check(!dec_valid, "R8 bubble after redirect", 32'(dec_valid), 0);
      if (hold_chk) check(dec_valid && dec_hw0 == held_h0, "R11 untaken instruction held", 32'(dec_hw0), 32'(held_h0));
      if (!redir_now && ($urandom % 50) == 0) begin
        redir_now = 1;
        redir_tgt = pick_target();
      end
      tk = !redir_now && dec_valid && ($urandom % 3 != 0);
      if (tk) begin
        e = exp_q.pop_front();
        check(dec_len == e.len, "R2 length", 32'(dec_len), 32'(e.len));
        check(dec_hw0 == e.h0, "R5 next instruction start", 32'(dec_hw0), 32'(e.h0));
        if (e.len >= 2) check(dec_hw1 == e.h1, "R4 second halfword", 32'(dec_hw1), 32'(e.h1));
        if (e.len == 3) check(dec_hw2 == e.h2, "R4 third halfword", 32'(dec_hw2), 32'(e.h2));
      end
      hold_chk = dec_valid && !tk && !redir_now;
      held_h0 = dec_hw0;
    end else begin
      tk = dir_take && dec_valid;
    end
    after_redir = redir_now;
    // fetch port model
    fe_rsp_valid = 1'b0;
    fe_rsp_data = '0;
    if (pend.size() > 0 && pend[0].ready <= cyc && budget != 0) begin
      fe_rsp_valid = 1'b1;
      fe_rsp_data = word_at(pend[0].addr);
      void'(pend.pop_front());
      if (budget > 0) budget--;
    end
    fe_req_ack = ack_en && (dir_mode || ($urandom % 4 != 0));
    if (fe_req_valid && fe_req_ack) begin
      check(fe_req_addr == exp_fa, "R7 fetch address", fe_req_addr, exp_fa);
      exp_fa = exp_fa + 32'd4;
      acc_since++;
      pend.push_back('{fe_req_addr, cyc + 1 + (dir_mode ? 0 : int'($urandom % 4))});
    end
    // consumer and redirect
    dec_take = tk;
    redirect_valid = redir_now;
    redirect_addr = redir_tgt[31:1];
    if (redir_now) begin
      exp_q.delete();
      exp_pc = redir_tgt;
      exp_fa = {redir_tgt[31:2], 2'b00};
      acc_since = 0;
    end
    fill_expected();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(!dec_valid, "R1 reset valid low", 32'(dec_valid), 0);
    check(fe_req_valid, "R1 reset request offered", 32'(fe_req_valid), 1);
    check(fe_req_addr == 32'h0, "R1 reset address", fe_req_addr, 0);

    // Bubbles on empty and partial queue
    ack_en = 0; budget = 0; dir_take = 0;
    redir_tgt = 32'h8000; redir_pend = 1; tick();
    ack_en = 1;
    repeat (4) tick();
    check(!dec_valid, "R3 empty queue bubble", 32'(dec_valid), 0);
    check(acc_since == 2, "R6 in-flight limit", acc_since, 2);
    budget = 1; tick(); tick();
    check(!dec_valid, "R3 partial instruction bubble", 32'(dec_valid), 0);
    budget = 1; tick(); tick();
    check(dec_valid && dec_len == 2'd3, "R3 complete three-halfword", 32'(dec_len), 3);
    check(dec_hw0 == hw_at(32'h8000), "R4 low half first", 32'(dec_hw0), 32'(hw_at(32'h8000)));
    check(dec_hw1 == hw_at(32'h8002), "R4 high half second", 32'(dec_hw1), 32'(hw_at(32'h8002)));
    check(dec_hw2 == hw_at(32'h8004), "R4 next word low half", 32'(dec_hw2), 32'(hw_at(32'h8004)));

    // Redirect with words in flight, odd target
    redir_tgt = 32'h8002; redir_pend = 1; tick(); tick();
    check(!dec_valid, "R8 flush empties queue", 32'(dec_valid), 0);
    budget = -1;
    repeat (16) tick();
    check(dec_valid && dec_hw0 == hw_at(32'h8002), "R9 odd target skips low half", 32'(dec_hw0), 32'(hw_at(32'h8002)));
    check(dec_hw1 == hw_at(32'h8004), "R10 stale words dropped", 32'(dec_hw1), 32'(hw_at(32'h8004)));
    check(acc_since == 4, "R6 capacity with reservation", acc_since, 4);
    dir_take = 1; tick(); dir_take = 0;
    repeat (6) tick();
    check(dec_valid && dec_hw0 == hw_at(32'h8008), "R5 consume removes exactly len", 32'(dec_hw0), 32'(hw_at(32'h8008)));
    check(acc_since == 6, "R6 refill after consume", acc_since, 6);

    // Random scoreboard phase
    dir_mode = 0; hold_chk = 0; after_redir = 0;
    redir_tgt = 32'h0100; redir_pend = 1;
    repeat (4000) tick();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule